// File: doc/BRIEF.md
# Diagnostic Output Selector with Divider Bypass

This block picks one internal node of a clock synthesizer and drives it onto a single low-speed diagnostic pin. A 3-bit test code chooses the node. The choices are two constants, the serial shift-register bit, the reference clock halved, the feedback-counter output, the synthesized output and the synthesized output divided by four. Every source is handled as a level, or as a one-cycle tick, inside one fast simulation clock domain. Nothing in the block multiplexes a clock through logic.

One code selects a debug bypass. In that mode the serial programming clock stands in for the oscillator. Each serial tick steps a local post-divider, whose output is brought out for the output path. Each rising edge of that post-divider output then steps a local 7-bit feedback down-counter. A toggle stage on the counter's terminal count drives the diagnostic pin. The bypass selection is registered, and the local dividers are enabled only while that registered selection is set.

Top module: `tns_selector`

## Requirements
- R1: While reset is active, and after it is released with all inputs low, `test_o`, `bypass_o` and `byp_fout_o` are 0.
- R2: Test code 3'b001 makes `test_o` 1 and test code 3'b101 makes it 0, one clock after the code is applied.
- R3: Test code 3'b000 makes `test_o` show the shift bit captured on the most recent `sclk_tick_i`, one clock later.
- R4: Test code 3'b010 makes `test_o` show a toggle flop that inverts on every `ref_tick_i` and is reset to 0.
- R5: Test code 3'b011 makes `test_o` show `m_term_i` one clock later.
- R6: Test code 3'b100 makes `test_o` show `fout_i` two clocks later. Test code 3'b111 makes it show bit 1 of a 2-bit counter that advances on each rising edge of `fout_i`, which is the output divided by 4.
- R7: Test code 3'b110 sets `bypass_o` one clock later, and any other code clears it one clock later. The local dividers run only while `bypass_o` is 1.
- R8: In bypass, `byp_fout_o` inverts after every N serial ticks. The `n_sel_i` encoding is 2'b11 for N=1, 2'b00 for N=2, 2'b01 for N=4 and 2'b10 for N=8.
- R9: In bypass, with code 3'b110, `test_o` inverts once for every M rising edges of `byp_fout_o`, where M is `m_val_i`. M=0 behaves as M=1. The counter loads M on entry to bypass and again at each terminal count.
- R10: Outside bypass, `byp_fout_o` stays 0, and the local feedback toggle is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_code_i | input | 3 | Diagnostic node select |
| sclk_tick_i | input | 1 | One-cycle tick per serial clock rising edge |
| shift_bit_i | input | 1 | Serial shift-register output bit |
| ref_tick_i | input | 1 | One-cycle tick per reference clock edge |
| fout_i | input | 1 | Synthesized output level |
| m_term_i | input | 1 | Feedback counter output from the main path |
| m_val_i | input | 7 | Feedback divide value M |
| n_sel_i | input | 2 | Post-divider select |
| test_o | output | 1 | Diagnostic pin |
| bypass_o | output | 1 | Bypass mode active, for the output path |
| byp_fout_o | output | 1 | Post-divider output in bypass |

## Verification
Most selections reach `test_o` one clock after the code and source inputs are applied. The synthesized output level takes two clocks, because it is registered once before the selector. `bypass_o` follows the code after one clock, and the bypass dividers first respond one clock after that, once the registered enable is set. The bench drives every input on the falling edge. It advances its expected state once per rising edge, using the same inputs, and compares all three outputs on the following falling edge, so each check sees exactly the register stages named above.

// File: rtl/tns_pkg.sv
package tns_pkg;
  typedef enum logic [2:0] {
    TC_SHIFT = 3'b000,
    TC_ONE   = 3'b001,
    TC_REF2  = 3'b010,
    TC_MCNT  = 3'b011,
    TC_FOUT  = 3'b100,
    TC_ZERO  = 3'b101,
    TC_BYP   = 3'b110,
    TC_FOUT4 = 3'b111
  } test_code_e;

  localparam int unsigned N_SEL_W = 2;
endpackage

// File: rtl/tns_ndiv.sv
module tns_ndiv #(
  parameter int unsigned CW = 3
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        tick_i,
  input  logic [tns_pkg::N_SEL_W-1:0] nsel_i,
  output logic                        out_o,
  output logic                        rise_o
);
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          out_q, out_d, wrap;

  // R8: post-divider ratio decode
  always_comb begin
    unique case (nsel_i)
      2'b11:   lim = CW'(0);
      2'b00:   lim = CW'(1);
      2'b01:   lim = CW'(3);
      default: lim = CW'(7);
    endcase
  end

  assign wrap   = en_i && tick_i && (cnt_q == lim);
  assign rise_o = wrap && !out_q;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!en_i) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_d = '0;
        out_d = ~out_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> !out_o);
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(out_o));
endmodule

// File: rtl/tns_mdiv.sv
module tns_mdiv #(
  parameter int unsigned MW = 7
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          step_i,
  input  logic [MW-1:0] mval_i,
  output logic          tog_o
);
  logic [MW-1:0] cnt_q, cnt_d;
  logic          tog_q, tog_d, term;

  always_comb begin
    cnt_d = cnt_q;
    tog_d = tog_q;
    term  = 1'b0;
    if (!en_i) begin
      cnt_d = mval_i;
      tog_d = 1'b0;
    end else if (step_i) begin
      if (cnt_q <= MW'(1)) begin
        term  = 1'b1;
        cnt_d = mval_i;
        tog_d = ~tog_q;
      end else begin
        cnt_d = cnt_q - MW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign tog_o = tog_q;

  assert_tog_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(tog_o));
  assert_tog_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> !tog_o);
  assert_term_flip_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    term |=> (tog_o != $past(tog_o)));
endmodule

// File: rtl/tns_selector.sv
module tns_selector #(
  parameter int unsigned MW  = 7,
  parameter int unsigned NCW = 3,
  parameter int unsigned QW  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  test_code_i,
  input  logic                        sclk_tick_i,
  input  logic                        shift_bit_i,
  input  logic                        ref_tick_i,
  input  logic                        fout_i,
  input  logic                        m_term_i,
  input  logic [MW-1:0]               m_val_i,
  input  logic [tns_pkg::N_SEL_W-1:0] n_sel_i,
  output logic                        test_o,
  output logic                        bypass_o,
  output logic                        byp_fout_o
);
  import tns_pkg::*;

  localparam int unsigned QTOP = QW - 1;

  logic [1:0]    rs_q;
  logic          rst_i;
  logic          sr_q, sr_d, ref_q, ref_d, fprev_q, byp_q, byp_d, test_q, test_d;
  logic [QW-1:0] q4_q, q4_d;
  logic          n_rise, m_tog;
  test_code_e    code;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign code = test_code_e'(test_code_i);

  always_comb begin
    sr_d  = sclk_tick_i ? shift_bit_i : sr_q;
    ref_d = ref_tick_i ? ~ref_q : ref_q;
    q4_d  = (fout_i && !fprev_q) ? q4_q + QW'(1) : q4_q;
    byp_d = (code == TC_BYP);
    unique case (code)
      TC_SHIFT: test_d = sr_q;
      TC_ONE:   test_d = 1'b1;
      TC_REF2:  test_d = ref_q;
      TC_MCNT:  test_d = m_term_i;
      TC_FOUT:  test_d = fprev_q;
      TC_ZERO:  test_d = 1'b0;
      TC_BYP:   test_d = m_tog;
      default:  test_d = q4_q[QTOP];
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sr_q    <= 1'b0;
      ref_q   <= 1'b0;
      fprev_q <= 1'b0;
      q4_q    <= '0;
      byp_q   <= 1'b0;
      test_q  <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      ref_q   <= ref_d;
      fprev_q <= fout_i;
      q4_q    <= q4_d;
      byp_q   <= byp_d;
      test_q  <= test_d;
    end
  end

  tns_ndiv #(.CW(NCW)) u_ndiv (
    .clk    (clk),
    .rst_ni (rst_i),
    .en_i   (byp_q),
    .tick_i (sclk_tick_i),
    .nsel_i (n_sel_i),
    .out_o  (byp_fout_o),
    .rise_o (n_rise)
  );

  tns_mdiv #(.MW(MW)) u_mdiv (
    .clk    (clk),
    .rst_ni (rst_i),
    .en_i   (byp_q),
    .step_i (n_rise),
    .mval_i (m_val_i),
    .tog_o  (m_tog)
  );

  assign test_o   = test_q;
  assign bypass_o = byp_q;

  assert_const_one_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (test_code_i == 3'b001) |=> test_o);
  assert_const_zero_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (test_code_i == 3'b101) |=> !test_o);
  assert_bypass_follow_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (test_code_i == 3'b110) |=> bypass_o);
  assert_bypass_drop_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (test_code_i != 3'b110) |=> !bypass_o);
  assert_mterm_pass_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (test_code_i == 3'b011) |=> (test_o == $past(m_term_i)));
  assert_ref_flip_R4: assert property (@(posedge clk) disable iff (!rst_i)
    ref_tick_i |=> (ref_q != $past(ref_q)));
endmodule

// File: tb/tb_tns_selector.sv
module tb_tns_selector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] code;
  logic       stick, sbit, rtick, fo, mterm;
  logic [6:0] mval;
  logic [1:0] nsel;
  logic       test_o, bypass_o, byp_fout_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // expected state, advanced per rising edge from the requirements
  bit       e_sr, e_ref, e_fprev, e_byp, e_test, e_nout, e_tog;
  bit [1:0] e_q4;
  bit [2:0] e_ncnt;
  bit [6:0] e_mcnt;

  always #5 clk = ~clk;

  tns_selector dut (
    .clk(clk), .rst_n(rst_n), .test_code_i(code), .sclk_tick_i(stick),
    .shift_bit_i(sbit), .ref_tick_i(rtick), .fout_i(fo), .m_term_i(mterm),
    .m_val_i(mval), .n_sel_i(nsel), .test_o(test_o), .bypass_o(bypass_o),
    .byp_fout_o(byp_fout_o)
  );

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000: return "R3";
      3'b001: return "R2";
      3'b101: return "R2";
      3'b010: return "R4";
      3'b011: return "R5";
      3'b110: return "R9";
      default: return "R6";
    endcase
  endfunction

  function automatic bit [2:0] n_lim(input bit [1:0] s);
    case (s)
      2'b11: return 3'd0;
      2'b00: return 3'd1;
      2'b01: return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  task automatic check(input string rq, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rise, n_sr, n_ref, n_tog, n_nout, n_test;
    bit [1:0] n_q4;
    bit [2:0] n_ncnt;
    bit [6:0] n_mcnt;
    n_sr  = stick ? sbit : e_sr;
    n_ref = rtick ? ~e_ref : e_ref;
    n_q4  = (fo && !e_fprev) ? e_q4 + 2'd1 : e_q4;
    rise  = 1'b0;
    n_ncnt = e_ncnt; n_nout = e_nout;
    if (!e_byp) begin n_ncnt = 0; n_nout = 0; end              // R10
    else if (stick) begin                                       // R8
      if (e_ncnt == n_lim(nsel)) begin
        rise = !e_nout; n_ncnt = 0; n_nout = ~e_nout;
      end else n_ncnt = e_ncnt + 3'd1;
    end
    n_mcnt = e_mcnt; n_tog = e_tog;
    if (!e_byp) begin n_mcnt = mval; n_tog = 0; end
    else if (rise) begin                                        // R9
      if (e_mcnt <= 7'd1) begin n_mcnt = mval; n_tog = ~e_tog; end
      else n_mcnt = e_mcnt - 7'd1;
    end
    case (code)
      3'b000: n_test = e_sr;
      3'b001: n_test = 1'b1;
      3'b010: n_test = e_ref;
      3'b011: n_test = mterm;
      3'b100: n_test = e_fprev;
      3'b101: n_test = 1'b0;
      3'b110: n_test = e_tog;
      default: n_test = e_q4[1];
    endcase
    e_sr = n_sr; e_ref = n_ref; e_q4 = n_q4; e_fprev = fo;
    e_byp = (code == 3'b110);                                   // R7
    e_ncnt = n_ncnt; e_nout = n_nout; e_mcnt = n_mcnt; e_tog = n_tog;
    e_test = n_test;
  endtask

  // compare at falling edge, drive new inputs, advance model after rising edge
  task automatic cyc(input logic [2:0] c, input bit st, input bit sb, input bit rt,
                     input bit f, input bit mt);
    logic [2:0] prev;
    @(negedge clk);
    prev = code;
    check(req_of(prev), test_o, e_test);
    check("R7", bypass_o, e_byp);
    check(e_byp ? "R8" : "R10", byp_fout_o, e_nout);
    code = c; stick = st; sbit = sb; rtick = rt; fo = f; mterm = mt;
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic phase(input logic [2:0] c, input int len, input logic [6:0] mv,
                       input logic [1:0] ns, input bit every_tick);
    mval = mv; nsel = ns;
    for (int i = 0; i < len; i++) begin
      bit st;
      st = every_tick ? 1'b1 : (($urandom % 3) == 0);
      cyc(c, st, $urandom % 2, ($urandom % 4) == 0,
          (($urandom % 3) == 0) ? ~fo : fo, $urandom % 2);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; code = 3'b000; stick = 0; sbit = 0; rtick = 0; fo = 0;
    mterm = 0; mval = 0; nsel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", test_o, 1'b0);
    check("R1", bypass_o, 1'b0);
    check("R1", byp_fout_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) cyc(3'b000, 0, 0, 0, 0, 0);
    // directed corners
    phase(3'b001, 5, 0, 0, 0);
    phase(3'b101, 5, 0, 0, 0);
    phase(3'b110, 60, 7'd0, 2'b11, 1);  // M=0 as 1, N=1
    phase(3'b110, 80, 7'd3, 2'b00, 1);  // N=2
    phase(3'b110, 120, 7'd2, 2'b01, 1); // N=4
    phase(3'b110, 200, 7'd1, 2'b10, 1); // N=8
    phase(3'b111, 40, 0, 0, 0);
    phase(3'b100, 20, 0, 0, 0);
    phase(3'b010, 30, 0, 0, 0);
    // constrained random
    for (int p = 0; p < 60; p++) begin
      logic [2:0] c;
      c = 3'($urandom % 8);
      phase(c, (c == 3'b110) ? 80 + ($urandom % 80) : 10 + ($urandom % 40),
            7'($urandom % 6), 2'($urandom % 4), ($urandom % 2) == 1);
    end
    @(negedge clk);
    check(req_of(code), test_o, e_test);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule